// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock

This block is a memory-mapped real-time clock. A prescaler divides the reference clock into a one-second tick. A 32-bit register counts seconds on that tick. Software reaches the block over a simple synchronous bus with address, write enable, read strobe, write data and registered read data.

Software can read the running count and stage a new count. A staged count lands only on the next one-second update, never at once. Software can also program an alarm value. When an update brings the count to that value, a sticky condition is raised. The condition drives an interrupt line through an enable bit and a mask bit. A read of a dedicated acknowledge address clears the condition, with no write needed.

Top module: `sec_rtc`

## Requirements
- R1: After reset, the count, alarm, staged-load and control registers are 0, both status registers read 0, and `irq` is 0.
- R2: Byte offsets are: count 0x00 (read-only, writes ignored), alarm 0x04, staged load 0x08, control 0x0C, gated status 0x10, raw status 0x14, acknowledge 0x18. Read data appears on `bus_rdata` one cycle after the read strobe.
- R3: Control bits are 0 interrupt enable, 1 interrupt mask, 2 counter run, 3 wrap allow. The other bits read as 0.
- R4: While the run bit is 1, the count rises by exactly one every PRESCALE clock cycles.
- R5: While the run bit is 0, the prescaler and the count hold their values, and a staged load waits until counting resumes.
- R6: A write to the staged-load register leaves the readable count unchanged until the next one-second update. At that update the count takes the written value.
- R7: At 0xFFFFFFFF, an update moves the count to 0 when wrap allow is 1. When wrap allow is 0, the count stays at 0xFFFFFFFF.
- R8: Raw status bit 0 becomes 1 after an update that leaves the count equal to the alarm value. This happens whatever the enable and mask bits are. The bit stays 1 until an acknowledge read, and reading the status registers does not clear it.
- R9: Gated status bit 0 equals raw AND enable AND NOT mask. `irq` follows that value one cycle later.
- R10: A read of the acknowledge address clears raw status and returns 0. A write to that address has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address of the access |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Registered alarm interrupt |

## Verification
The properties assume that a read strobe and a write strobe are never both high in one cycle. They also assume that a strobe lasts only for the cycle of its access, so one acknowledge read clears the condition once. The bench keeps within these assumptions by issuing every access through a task. Each task raises one strobe for a single cycle on the falling edge and then drops it. While a staged load or a counter-register write must be seen not to land, the counter is stopped, so no tick can hide the check.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] OFS_COUNT = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_ALARM = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_STAGE = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_GATED = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_ACK   = 5'h18;

  typedef struct packed {
    logic wrap;
    logic en;
    logic mask;
    logic ie;
  } ctrl_t;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] phase;

  assign tick = run && (phase == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (run) begin
      if (phase == LAST) phase <= '0;
      else               phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          wrap_ok,
  input  logic          stage_we,
  input  logic [CW-1:0] stage_data,
  output logic [CW-1:0] count,
  output logic [CW-1:0] stage_q,
  output logic          upd
);
  logic pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      stage_q <= '0;
      pend    <= 1'b0;
      upd     <= 1'b0;
    end else begin
      upd <= tick;
      if (tick) begin
        if (pend)        count <= stage_q;
        else if (&count) begin
          if (wrap_ok)   count <= '0;
        end else         count <= count + 1'b1;
      end
      if (stage_we) begin
        stage_q <= stage_data;
        pend    <= 1'b1;
      end else if (tick) begin
        pend    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] alarm,
  input  logic          ack_rd,
  input  logic          ie,
  input  logic          mask,
  output logic          hit,
  output logic          raw,
  output logic          irq
);
  assign hit = upd && (count == alarm);

  always_ff @(posedge clk) begin
    if (rst) begin
      raw <= 1'b0;
      irq <= 1'b0;
    end else begin
      if (hit)         raw <= 1'b1;
      else if (ack_rd) raw <= 1'b0;
      irq <= raw & ie & ~mask;
    end
  end
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc #(
  parameter int PRESCALE = 32768
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [rtc_pkg::ADDR_W-1:0]  bus_addr,
  input  logic                        bus_we,
  input  logic                        bus_re,
  input  logic [rtc_pkg::DATA_W-1:0]  bus_wdata,
  output logic [rtc_pkg::DATA_W-1:0]  bus_rdata,
  output logic                        irq
);
  import rtc_pkg::*;

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] alarm_q;
  logic [DATA_W-1:0] count;
  logic [DATA_W-1:0] load_q;
  logic              tick;
  logic              upd;
  logic              hit;
  logic              raw;
  logic              gated;
  logic              ack_rd;
  logic              stage_we;
  logic [DATA_W-1:0] rd_mux;

  assign stage_we = bus_we && (bus_addr == OFS_STAGE);
  assign ack_rd   = bus_re && (bus_addr == OFS_ACK);
  assign gated    = raw & ctrl_q.ie & ~ctrl_q.mask;

  rtc_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk (clk), .rst (rst), .run (ctrl_q.en), .tick (tick)
  );

  rtc_counter #(.CW(DATA_W)) u_cnt (
    .clk (clk), .rst (rst), .tick (tick), .wrap_ok (ctrl_q.wrap),
    .stage_we (stage_we), .stage_data (bus_wdata),
    .count (count), .stage_q (load_q), .upd (upd)
  );

  rtc_alarm #(.CW(DATA_W)) u_alm (
    .clk (clk), .rst (rst), .upd (upd), .count (count), .alarm (alarm_q),
    .ack_rd (ack_rd), .ie (ctrl_q.ie), .mask (ctrl_q.mask),
    .hit (hit), .raw (raw), .irq (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      alarm_q <= '0;
    end else if (bus_we) begin
      if (bus_addr == OFS_CTRL)  ctrl_q  <= ctrl_t'(bus_wdata[3:0]);
      if (bus_addr == OFS_ALARM) alarm_q <= bus_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_COUNT: rd_mux = count;
      OFS_ALARM: rd_mux = alarm_q;
      OFS_STAGE: rd_mux = load_q;
      OFS_CTRL:  rd_mux = {{(DATA_W-4){1'b0}}, ctrl_q};
      OFS_GATED: rd_mux = {{(DATA_W-1){1'b0}}, gated};
      OFS_RAW:   rd_mux = {{(DATA_W-1){1'b0}}, raw};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end
endmodule

// File: rtl/sec_rtc_checker.sv
module sec_rtc_checker (
  input logic                       clk,
  input logic                       rst,
  input logic [rtc_pkg::ADDR_W-1:0] bus_addr,
  input logic                       bus_we,
  input logic                       bus_re,
  input logic [31:0]                count,
  input logic [31:0]                load_q,
  input logic                       tick,
  input logic                       hit,
  input logic                       raw,
  input logic                       irq,
  input rtc_pkg::ctrl_t             ctrl_q
);
  import rtc_pkg::*;

  a_r2_count_readonly: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFS_COUNT && !tick) |=> $stable(count));

  a_r4_single_step: assert property (@(posedge clk) disable iff (rst)
    (count != $past(count)) |->
      ((count == $past(count) + 32'd1) || (count == $past(load_q)) || (count == 32'd0)));

  a_r5_hold_when_off: assert property (@(posedge clk) disable iff (rst)
    !$past(ctrl_q.en) |-> $stable(count));

  a_r6_load_deferred: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFS_STAGE && !tick) |=> $stable(count));

  a_r8_raw_sticky: assert property (@(posedge clk) disable iff (rst)
    (raw && !(bus_re && bus_addr == OFS_ACK)) |=> raw);

  a_r9_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(ctrl_q.ie) && !$past(ctrl_q.mask) && $past(raw)));

  a_r10_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == OFS_ACK && !hit) |=> !raw);
endmodule

bind sec_rtc sec_rtc_checker u_chk (.*);

// File: tb/sec_rtc_bench.sv
module sec_rtc_bench;
  import rtc_pkg::*;

  localparam int DIV = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [31:0] rv;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sec_rtc #(.PRESCALE(DIV)) u_sec_rtc (
    .clk (clk), .rst (rst), .bus_addr (bus_addr), .bus_we (bus_we),
    .bus_re (bus_re), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .irq (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_change(input logic [31:0] old, output logic [31:0] nv, output int at);
    nv = old;
    at = 0;
    for (int i = 0; i < 200; i++) begin
      rd(OFS_COUNT, nv);
      if (nv != old) begin
        at = cyc;
        break;
      end
    end
  endtask

  task automatic t_reset;
    rd(OFS_COUNT, rv); check("R1 count", rv, 32'd0);
    rd(OFS_CTRL,  rv); check("R1 ctrl", rv, 32'd0);
    rd(OFS_ALARM, rv); check("R1 alarm", rv, 32'd0);
    rd(OFS_RAW,   rv); check("R1 raw", rv, 32'd0);
    rd(OFS_GATED, rv); check("R1 gated", rv, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    idle(3 * DIV);
    rd(OFS_COUNT, rv); check("R5 idle after reset", rv, 32'd0);
  endtask

  task automatic t_regmap;
    wr(OFS_ALARM, 32'hA5A5_0001);
    rd(OFS_ALARM, rv); check("R2 alarm rw", rv, 32'hA5A5_0001);
    wr(OFS_CTRL, 32'hFFFF_FFF3);
    rd(OFS_CTRL, rv); check("R3 ctrl bits", rv, 32'h0000_0003);
    wr(OFS_CTRL, 32'h0);
    wr(OFS_COUNT, 32'h0000_0055);
    rd(OFS_COUNT, rv); check("R2 count readonly", rv, 32'd0);
  endtask

  task automatic t_load_hold;
    logic [31:0] nv;
    int at;
    wr(OFS_STAGE, 32'd1000);
    rd(OFS_STAGE, rv); check("R2 stage readback", rv, 32'd1000);
    rd(OFS_COUNT, rv); check("R6 not immediate", rv, 32'd0);
    idle(4 * DIV);
    rd(OFS_COUNT, rv); check("R5 pending waits", rv, 32'd0);
    wr(OFS_CTRL, 32'h4);
    wait_change(32'd0, nv, at);
    check("R6 load lands", nv, 32'd1000);
  endtask

  task automatic t_period;
    logic [31:0] a, b;
    int t1, t2;
    rd(OFS_COUNT, rv);
    wait_change(rv, a, t1);
    wait_change(a, b, t2);
    check("R4 step", b, a + 32'd1);
    check("R4 period", 32'(t2 - t1), 32'(DIV));
    wr(OFS_CTRL, 32'h0);
    rd(OFS_COUNT, a);
    idle(3 * DIV);
    rd(OFS_COUNT, b); check("R5 hold", b, a);
  endtask

  task automatic t_wrap;
    logic [31:0] nv;
    int at;
    wr(OFS_STAGE, 32'hFFFF_FFFE);
    wr(OFS_CTRL, 32'hC);
    rd(OFS_COUNT, rv);
    wait_change(rv, nv, at);          check("R6 load FFFFFFFE", nv, 32'hFFFF_FFFE);
    wait_change(nv, nv, at);          check("R7 reach max", nv, 32'hFFFF_FFFF);
    wait_change(nv, nv, at);          check("R7 wrap to zero", nv, 32'd0);
    wr(OFS_CTRL, 32'h0);
    wr(OFS_STAGE, 32'hFFFF_FFFF);
    wr(OFS_CTRL, 32'h4);
    rd(OFS_COUNT, rv);
    wait_change(rv, nv, at);          check("R6 load max", nv, 32'hFFFF_FFFF);
    idle(4 * DIV);
    rd(OFS_COUNT, rv);                check("R7 hold at max", rv, 32'hFFFF_FFFF);
    wr(OFS_CTRL, 32'h0);
  endtask

  task automatic t_alarm;
    logic [31:0] nv;
    wr(OFS_STAGE, 32'd100);
    wr(OFS_ALARM, 32'd102);
    rd(OFS_ACK, rv);                  check("R10 ack reads zero", rv, 32'd0);
    rd(OFS_RAW, rv);                  check("R10 cleared before run", rv, 32'd0);
    wr(OFS_CTRL, 32'h4);
    nv = 32'd0;
    for (int i = 0; i < 500; i++) begin
      rd(OFS_COUNT, nv);
      if (nv == 32'd102) break;
    end
    check("R8 reached alarm", nv, 32'd102);
    idle(2);
    rd(OFS_RAW, rv);                  check("R8 raw set while disabled", rv, 32'd1);
    rd(OFS_RAW, rv);                  check("R8 raw read keeps", rv, 32'd1);
    rd(OFS_GATED, rv);                check("R9 gated off", rv, 32'd0);
    check("R9 irq off", {31'd0, irq}, 32'd0);
    wr(OFS_CTRL, 32'h5);
    idle(1);
    check("R9 irq on", {31'd0, irq}, 32'd1);
    rd(OFS_GATED, rv);                check("R9 gated on", rv, 32'd1);
    wr(OFS_CTRL, 32'h7);
    idle(1);
    check("R9 masked irq", {31'd0, irq}, 32'd0);
    rd(OFS_GATED, rv);                check("R9 masked gated", rv, 32'd0);
    wr(OFS_CTRL, 32'h5);
    wr(OFS_ACK, 32'hFFFF_FFFF);
    rd(OFS_RAW, rv);                  check("R10 ack write ignored", rv, 32'd1);
    idle(1);
    check("R10 irq before ack", {31'd0, irq}, 32'd1);
    rd(OFS_ACK, rv);                  check("R10 ack value", rv, 32'd0);
    idle(1);
    rd(OFS_RAW, rv);                  check("R10 raw cleared", rv, 32'd0);
    check("R10 irq cleared", {31'd0, irq}, 32'd0);
    wr(OFS_CTRL, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_load_hold();
    t_period();
    t_wrap();
    t_alarm();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule